// File: doc/BRIEF.md
# Host bus mode controller

This block sits between a host cartridge bus and two local devices: a parallel flash and the host-port interface of a coprocessor. Each host access is one cycle long and carries a byte offset. Offsets in the flash window go to the flash. A single control offset either moves coprocessor data or carries command words and status. A 4-bit mode register decides what each access does and which fixed levels the local strobes take.

The mode register is also a loadable up-counter. When its top bit is set, the block is in burst data mode. The low three bits then count the words moved so far, so eight minus the count is the number of words left. An address-set command enters burst mode. A mode-set command loads any of the low modes: idle, the three serial-EEPROM sub-modes, host boot, coprocessor boot and flash write. A holding register captures coprocessor read data in EEPROM read mode and supplies the outbound coprocessor data in the EEPROM write and command modes. Strobes and output enables are decoded combinationally from the access and the current mode. Only the command processing is registered.

Top module: `hbus_mode_ctrl`

## Requirements
- R1: After reset the mode reads 0100 (host boot), the coprocessor address output is 0x0000, and the holding register is cleared.
- R2: A write to the control offset outside data mode whose bits 15:14 are 01 is a mode set: the mode becomes {0, bits 2:0}, with bit 3 of the word ignored. The exact word 0x4000 instead returns every register to its reset state.
- R3: A command word with bits 15:14 equal to 00 is an address set. The coprocessor address becomes {0011, bits 11:0} and the mode becomes 1000 (burst, zero words moved).
- R4: A command word with bits 15:14 equal to 10 is a joystick address set. The address becomes 0011_0000_0 in bits 15:7, J3&J2&J1&J0 in bit 6, then J3&J7, J2&J6, J1&J5, J0&J4 in bits 5:2, and 00 in bits 1:0. The mode is unchanged.
- R5: A command word with bits 15:14 equal to 11 changes neither the mode nor the address.
- R6: Data mode is burst mode with fewer than eight words moved. Each data access adds one to the low count. The count stops at 111, and the eighth access ends data mode while the mode stays 1111. From then on the control offset again returns status and takes commands.
- R7: A read at an offset from 0x80 to 0xBF drives flash_oe_n low and hst_oe high and returns flash_rdata, in every mode except 0101.
- R8: A write in the flash window pulls flash_we_n low only in mode 0110.
- R9: In data mode, a read at 0xC0 pulls cop_rd_n low and returns cop_rdata. A write there pulls cop_wr_n low and is not decoded as a command.
- R10: Outside data mode, a read at 0xC0 returns cop_status and leaves cop_rd_n high.
- R11: In mode 0101 cop_rd_n and cop_wr_n are held low and flash_oe_n is held high, whatever the host access.
- R12: cop_wdata is the holding register in modes 0001 and 0011 and hst_wdata in every other mode.
- R13: In mode 0010 a read at 0xC0 loads cop_rdata into the holding register.
- R14: An access outside 0x80–0xBF and 0xC0 drives no strobe and leaves hst_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_sel | input | 1 | Host access valid this cycle |
| hst_wr | input | 1 | Access is a write (1) or read (0) |
| hst_addr | input | 8 | Host byte offset |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_oe | output | 1 | Block drives the host data bus |
| joy_in | input | 8 | Joystick lines J7..J0 |
| flash_rdata | input | 16 | Flash read data |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| cop_rdata | input | 16 | Coprocessor port read data |
| cop_status | input | 16 | Coprocessor port status word |
| cop_rd_n | output | 1 | Coprocessor read strobe, active low |
| cop_wr_n | output | 1 | Coprocessor write strobe, active low |
| cop_wdata | output | 16 | Outbound coprocessor data |
| cop_addr | output | 16 | Latched coprocessor address |
| mode_o | output | 4 | Current mode register |

## Verification
The bench builds the block with its default windows: flash at offsets 0x80 to 0xBF and control at 0xC0, on an 8-bit offset. This puts the window edges 0x7F, 0x80, 0xBF and 0xC1 next to the control port, so all of them can be probed directly. The 3-bit burst count lets one sequence run a complete eight-word burst. That sequence shows the count saturating, command words being treated as data during the burst, and the control port returning to commands after the burst.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int DATA_W  = 16;
    localparam int MODE_W  = 4;
    localparam int CNT_W   = MODE_W - 1;

    localparam logic [MODE_W-1:0] MD_IDLE     = 4'b0000;
    localparam logic [MODE_W-1:0] MD_E2_WR    = 4'b0001;
    localparam logic [MODE_W-1:0] MD_E2_RD    = 4'b0010;
    localparam logic [MODE_W-1:0] MD_E2_CMD   = 4'b0011;
    localparam logic [MODE_W-1:0] MD_HOSTBOOT = 4'b0100;
    localparam logic [MODE_W-1:0] MD_COPBOOT  = 4'b0101;
    localparam logic [MODE_W-1:0] MD_FLASH_WR = 4'b0110;
    localparam logic [MODE_W-1:0] MD_BURST0   = 4'b1000;

    localparam logic [DATA_W-1:0] RESET_WORD  = 16'h4000;

    typedef enum logic [1:0] {
        OP_ADDR = 2'b00,
        OP_MODE = 2'b01,
        OP_JOY  = 2'b10,
        OP_NONE = 2'b11
    } cmd_op_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              done;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] hold;
    } ctl_state_t;
endpackage

// File: rtl/hbus_addr_decode.sv
module hbus_addr_decode #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] FLASH_LO = 8'h80,
    parameter logic [ADDR_W-1:0] FLASH_HI = 8'hBF,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'hC0
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              flash_hit,
    output logic              ctrl_hit
);
    always_comb begin
        flash_hit = sel && (addr >= FLASH_LO) && (addr <= FLASH_HI);
        ctrl_hit  = sel && (addr == CTRL_OFS);
    end
endmodule

// File: rtl/hbus_cmd_decode.sv
module hbus_cmd_decode
    import hbus_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [7:0]        joy,
    output cmd_op_e           op,
    output logic [CNT_W-1:0]  mode_ld,
    output logic [DATA_W-1:0] addr_ld,
    output logic              is_reset
);
    logic [DATA_W-1:0] joy_addr;

    always_comb begin
        joy_addr       = 16'h3000;
        joy_addr[6]    = &joy[3:0];
        for (int i = 0; i < 4; i++) begin
            joy_addr[2+i] = joy[i] & joy[4+i];
        end
    end

    always_comb begin
        op       = cmd_op_e'(word[15:14]);
        mode_ld  = word[CNT_W-1:0];
        is_reset = (word == RESET_WORD);
        addr_ld  = (op == OP_JOY) ? joy_addr : {4'b0011, word[11:0]};
    end
endmodule

// File: rtl/hbus_mode_fsm.sv
module hbus_mode_fsm
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  cmd_op_e           op,
    input  logic [CNT_W-1:0]  mode_ld,
    input  logic [DATA_W-1:0] addr_ld,
    input  logic              is_reset,
    input  logic              data_acc,
    input  logic              e2_latch,
    input  logic [DATA_W-1:0] cop_rdata,
    output logic [MODE_W-1:0] mode_q,
    output logic              done_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] hold_q
);
    localparam ctl_state_t RST_STATE = '{mode: MD_HOSTBOOT, done: 1'b0,
                                         addr: '0, hold: '0};

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_stb) begin
            if (is_reset) begin
                st_d = RST_STATE;
            end else begin
                case (op)
                    OP_MODE: begin
                        st_d.mode = {1'b0, mode_ld};
                        st_d.done = 1'b0;
                    end
                    OP_ADDR: begin
                        st_d.addr = addr_ld;
                        st_d.mode = MD_BURST0;
                        st_d.done = 1'b0;
                    end
                    OP_JOY:  st_d.addr = addr_ld;
                    default: ;
                endcase
            end
        end else if (data_acc) begin
            if (&st_q.mode[CNT_W-1:0]) begin
                st_d.done = 1'b1;
            end else begin
                st_d.mode[CNT_W-1:0] = st_q.mode[CNT_W-1:0] + 1'b1;
            end
        end
        if (e2_latch && !(cmd_stb && is_reset)) begin
            st_d.hold = cop_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign done_q = st_q.done;
    assign addr_q = st_q.addr;
    assign hold_q = st_q.hold;

    // R3
    addr_set_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && op == OP_ADDR) |=> (mode_q == MD_BURST0 && !done_q));

    // R2
    mode_set_clears_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && op == OP_MODE) |=> !mode_q[MODE_W-1]);

    // R5
    reserved_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && op == OP_NONE) |=> ($stable(mode_q) && $stable(addr_q)));

    // R6
    done_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (mode_q == 4'b1111));

    // R6
    burst_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[MODE_W-1] && !cmd_stb) |=>
        (mode_q[MODE_W-1] && mode_q[CNT_W-1:0] >= $past(mode_q[CNT_W-1:0])));
endmodule

// File: rtl/hbus_mode_ctrl.sv
module hbus_mode_ctrl
    import hbus_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] FLASH_LO = 8'h80,
    parameter logic [ADDR_W-1:0] FLASH_HI = 8'hBF,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_sel,
    input  logic              hst_wr,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [15:0]       hst_wdata,
    output logic [15:0]       hst_rdata,
    output logic              hst_oe,
    input  logic [7:0]        joy_in,
    input  logic [15:0]       flash_rdata,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    input  logic [15:0]       cop_rdata,
    input  logic [15:0]       cop_status,
    output logic              cop_rd_n,
    output logic              cop_wr_n,
    output logic [15:0]       cop_wdata,
    output logic [15:0]       cop_addr,
    output logic [3:0]        mode_o
);
    logic              flash_hit, ctrl_hit;
    cmd_op_e           op;
    logic [CNT_W-1:0]  mode_ld;
    logic [DATA_W-1:0] addr_ld, hold_q;
    logic              is_reset, done_q;
    logic [MODE_W-1:0] mode_q;
    logic              data_mode, ctrl_rd, ctrl_wr, cmd_stb, data_acc, e2_latch;
    logic              cop_boot, flash_off;

    hbus_addr_decode #(
        .ADDR_W(ADDR_W), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI), .CTRL_OFS(CTRL_OFS)
    ) u_dec (
        .sel(hst_sel), .addr(hst_addr), .flash_hit(flash_hit), .ctrl_hit(ctrl_hit)
    );

    hbus_cmd_decode u_cmd (
        .word(hst_wdata), .joy(joy_in), .op(op), .mode_ld(mode_ld),
        .addr_ld(addr_ld), .is_reset(is_reset)
    );

    always_comb begin
        data_mode = mode_q[MODE_W-1] && !done_q;
        ctrl_rd   = ctrl_hit && !hst_wr;
        ctrl_wr   = ctrl_hit && hst_wr;
        cmd_stb   = ctrl_wr && !data_mode;
        data_acc  = (ctrl_rd || ctrl_wr) && data_mode;
        e2_latch  = ctrl_rd && (mode_q == MD_E2_RD);
        cop_boot  = (mode_q == MD_COPBOOT);
        flash_off = cop_boot;
    end

    hbus_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .op(op), .mode_ld(mode_ld),
        .addr_ld(addr_ld), .is_reset(is_reset), .data_acc(data_acc),
        .e2_latch(e2_latch), .cop_rdata(cop_rdata), .mode_q(mode_q),
        .done_q(done_q), .addr_q(cop_addr), .hold_q(hold_q)
    );

    // Bus enables: purely combinational, independent of command latching
    always_comb begin
        flash_oe_n = !(flash_hit && !hst_wr && !flash_off);
        flash_we_n = !(flash_hit && hst_wr && mode_q == MD_FLASH_WR);
        cop_rd_n   = cop_boot ? 1'b0 : !(ctrl_rd && data_mode);
        cop_wr_n   = cop_boot ? 1'b0 : !(ctrl_wr && data_mode);
        hst_oe     = ctrl_rd || (flash_hit && !hst_wr && !flash_off);
        if (flash_hit)      hst_rdata = flash_rdata;
        else if (data_mode) hst_rdata = cop_rdata;
        else                hst_rdata = cop_status;
        if (!hst_oe) hst_rdata = '0;
        cop_wdata  = (mode_q[3:2] == 2'b00 && mode_q[0]) ? hold_q : hst_wdata;
    end

    assign mode_o = mode_q;

    // R11
    cop_boot_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_COPBOOT) |-> (!cop_rd_n && !cop_wr_n && flash_oe_n));

    // R14
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_sel && !flash_hit && !ctrl_hit && mode_o != MD_COPBOOT) |->
        (cop_rd_n && cop_wr_n && flash_oe_n && flash_we_n && !hst_oe));
endmodule

// File: tb/sim_hbus_mode_ctrl.sv
module sim_hbus_mode_ctrl;
    logic        clk = 0, rst_n = 0;
    logic        hst_sel = 0, hst_wr = 0;
    logic [7:0]  hst_addr = 0;
    logic [15:0] hst_wdata = 0;
    logic [15:0] hst_rdata;
    logic        hst_oe;
    logic [7:0]  joy_in = 0;
    logic [15:0] flash_rdata = 16'hA5A5, cop_rdata = 16'h1357, cop_status = 16'h5AC3;
    logic        flash_oe_n, flash_we_n, cop_rd_n, cop_wr_n;
    logic [15:0] cop_wdata, cop_addr;
    logic [3:0]  mode_o;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [15:0] s_rdata;
    logic s_oe, s_rd_n, s_wr_n, s_foe_n, s_fwe_n;

    always #10 clk = ~clk;

    hbus_mode_ctrl u0 (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        hst_sel = 1; hst_wr = wr; hst_addr = a; hst_wdata = d;
        #2;
        s_rdata = hst_rdata; s_oe = hst_oe; s_rd_n = cop_rd_n; s_wr_n = cop_wr_n;
        s_foe_n = flash_oe_n; s_fwe_n = flash_we_n;
        @(negedge clk);
        hst_sel = 0; hst_wr = 0;
    endtask

    task automatic cmd(input logic [15:0] d);
        acc(1'b1, 8'hC0, d);
    endtask

    function automatic logic [15:0] joy_exp(input logic [7:0] j);
        return {9'b001100000, &j[3:0], j[3]&j[7], j[2]&j[6], j[1]&j[5], j[0]&j[4], 2'b00};
    endfunction

    task automatic t_reset;
        chk("R1 mode", {12'd0, mode_o}, 16'h0004);
        chk("R1 addr", cop_addr, 16'h0000);
        cmd(16'h4001);
        hst_wdata = 16'hFFFF; #1;
        chk("R1 hold clear", cop_wdata, 16'h0000);
        cmd(16'h4000);
        chk("R2 reset word", {12'd0, mode_o}, 16'h0004);
    endtask

    task automatic t_windows;
        acc(1'b0, 8'h80, 0);
        chk("R7 oe_n@80", {15'd0, s_foe_n}, 0); chk("R7 data", s_rdata, 16'hA5A5);
        chk("R7 hst_oe", {15'd0, s_oe}, 1);
        acc(1'b0, 8'hBF, 0);
        chk("R7 oe_n@BF", {15'd0, s_foe_n}, 0);
        acc(1'b1, 8'h90, 16'h1111);
        chk("R8 we_n host boot", {15'd0, s_fwe_n}, 1);
        acc(1'b0, 8'h7F, 0);
        chk("R14 7F quiet", {11'd0, s_oe, s_foe_n, s_fwe_n, s_rd_n, s_wr_n}, 16'h000F);
        acc(1'b0, 8'hC1, 0);
        chk("R14 C1 quiet", {11'd0, s_oe, s_foe_n, s_fwe_n, s_rd_n, s_wr_n}, 16'h000F);
        acc(1'b0, 8'hC0, 0);
        chk("R10 status", s_rdata, 16'h5AC3); chk("R10 rd_n", {15'd0, s_rd_n}, 1);
    endtask

    task automatic t_modes;
        cmd(16'h4006);
        chk("R2 mode 0110", {12'd0, mode_o}, 16'h0006);
        acc(1'b1, 8'hA0, 16'h2222);
        chk("R8 we_n flash wr", {15'd0, s_fwe_n}, 0);
        cmd(16'h400D);
        chk("R2 bit3 dropped", {12'd0, mode_o}, 16'h0005);
        acc(1'b0, 8'h88, 0);
        chk("R11 strobes", {13'd0, s_rd_n, s_wr_n, s_foe_n}, 16'h0001);
        chk("R7 no flash in 0101", {15'd0, s_oe}, 0);
        cmd(16'hC123);
        chk("R5 mode kept", {12'd0, mode_o}, 16'h0005);
        chk("R5 addr kept", cop_addr, 16'h0000);
        cmd(16'h4000);
        chk("R2 reset to boot", {12'd0, mode_o}, 16'h0004);
    endtask

    task automatic t_joy;
        logic [7:0] pats [3] = '{8'hFF, 8'h05, 8'h5F};
        foreach (pats[k]) begin
            joy_in = pats[k];
            cmd(16'h8000);
            chk("R4 joy addr", cop_addr, joy_exp(pats[k]));
            chk("R4 mode kept", {12'd0, mode_o}, 16'h0004);
        end
    endtask

    task automatic t_burst;
        cmd(16'h0ABC);
        chk("R3 addr", cop_addr, 16'h3ABC);
        chk("R3 mode", {12'd0, mode_o}, 16'h0008);
        for (int i = 0; i < 8; i++) begin
            cop_rdata = 16'h0100 + 16'(i);
            if (i % 2 == 0) begin
                acc(1'b0, 8'hC0, 0);
                chk("R9 rd data", s_rdata, 16'h0100 + 16'(i));
                chk("R9 rd_n", {15'd0, s_rd_n}, 0);
            end else begin
                acc(1'b1, 8'hC0, 16'h4000);
                chk("R9 wr_n", {15'd0, s_wr_n}, 0);
            end
            chk("R6 count", {12'd0, mode_o}, (i < 7) ? 16'(9 + i) : 16'h000F);
        end
        acc(1'b0, 8'hC0, 0);
        chk("R6 status after burst", s_rdata, 16'h5AC3);
        chk("R6 no strobe", {15'd0, s_rd_n}, 1);
        chk("R6 mode held", {12'd0, mode_o}, 16'h000F);
        cmd(16'h4002);
        chk("R6 exit by command", {12'd0, mode_o}, 16'h0002);
    endtask

    task automatic t_e2;
        cop_rdata = 16'h2468;
        acc(1'b0, 8'hC0, 0);
        hst_wdata = 16'hFFFF; #1;
        chk("R12 0010 passthru", cop_wdata, 16'hFFFF);
        cmd(16'h4001);
        hst_wdata = 16'hFFFF; #1;
        chk("R13 hold latched", cop_wdata, 16'h2468);
        cmd(16'h4003);
        hst_wdata = 16'h0F0F; #1;
        chk("R12 0011 hold", cop_wdata, 16'h2468);
        cmd(16'h4004);
        hst_wdata = 16'h0F0F; #1;
        chk("R12 0100 passthru", cop_wdata, 16'h0F0F);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_windows;
        t_modes;
        t_joy;
        t_burst;
        t_e2;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog got=hung exp=done");
        finish_run;
    end
endmodule